// File: doc/BRIEF.md
# Framed Serial Transmitter with Break Generation

This block turns parallel data words into asynchronous serial frames on a single output line. A word is offered with a valid/ready handshake. It is sent as a low start bit, the data bits, an optional ninth bit and a high stop bit. The ninth bit is either even parity or a multidrop address flag supplied with the word. The data bits can go out least-significant first or most-significant first. The ninth bit does not move when the order changes: it always sits just before the stop bit.

Bit timing comes from a one-cycle baud enable (`tick`) supplied by the surrounding logic. Each serial bit lasts from one enable to the next, and the line is driven from a register.

A break request replaces normal traffic with frames that are entirely zero. A short request finishes the frame already on the line, sends exactly one zero frame and then releases the line. A request that is held keeps zero frames going back to back. In both cases the line is driven high for at least one bit before any new start bit.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset the line is high and no frame or break is sent until a word is accepted or a break is requested; reset also discards any pending break request.
- R2: `s_ready` is high only in a cycle with `tick` high in which the transmitter is idle or driving a stop bit and no break is requested (`brk` high now, or a one-shot request still pending). A word is taken on a clock edge with `s_valid` and `s_ready` both high.
- R3: A frame is a 0 start bit, then the data bits, then a 1 stop bit. Each bit holds for one tick period and the start bit begins at the edge that accepts the word. `fmt` selects the format: 0 gives 10 bits, 1 gives 11 bits with parity, 2 gives 11 bits with an address bit, and 3 behaves as 0.
- R4: With `msb_first` = 1 the data bits go out from bit 7 down to bit 0; with 0 they go out from bit 0 up to bit 7. The format and the order are captured when the word is accepted.
- R5: In format 1 the ninth bit is the even parity (XOR) of the 8 data bits. It is sent immediately before the stop bit whatever the bit order.
- R6: In format 2 the ninth bit is `s_addr` as captured with the word. It is sent immediately before the stop bit.
- R7: A word offered while the stop bit is on the line starts at the next bit time, with no idle bit in between.
- R8: A break frame is all zeros. Its length is 10 bits, or 11 when `fmt` is 1 or 2 at the moment the break frame starts.
- R9: If `brk` is high for at least one cycle and then falls, the frame in progress completes unchanged, then one break frame follows directly after its stop bit. No word is accepted in the meantime.
- R10: While `brk` stays high, break frames follow each other with no high bit between them.
- R11: When a break frame ends without a further break request, the line is driven high for at least one full bit before any new start bit.
- R12: `txd` changes only at a clock edge where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Baud enable, one pulse per bit time |
| fmt | input | 2 | Frame format: 0 plain, 1 parity, 2 address, 3 as plain |
| msb_first | input | 1 | 1 sends data MSB first, 0 LSB first |
| brk | input | 1 | Break request |
| s_valid | input | 1 | Data word valid |
| s_ready | output | 1 | Data word accepted this cycle if valid |
| s_data | input | DATA_W | Data word |
| s_addr | input | 1 | Address bit sent in format 2 |
| txd | output | 1 | Serial output line, idles high |

## Verification
Single bytes `01` and `80`-style patterns are sent in both orders. A wrong order then shows up as a mirrored frame, and a moved ninth bit shows up as a corrupted stop position. Random words with random format, order, address flag and idle gaps cover parity of both polarities and the capture of format and order at acceptance. Directed back-to-back words separate a correct stop-boundary handover from one that inserts idle bits. A break pulsed during a frame, followed by a waiting word, separates one-shot from continuous handling and checks the length of the zero run and the mark bit that follows. A held break is checked for a zero run that is a whole number of frames, with no acceptance during the run.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef enum logic [1:0] {
      FMT_PLAIN  = 2'd0,
      FMT_PARITY = 2'd1,
      FMT_ADDR   = 2'd2,
      FMT_RSVD   = 2'd3
   } fmt_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DATA = 2'd1,
      ST_BRK  = 2'd2
   } tx_st_e;

   function automatic logic fmt_long(input logic [1:0] f);
      return (f == FMT_PARITY) || (f == FMT_ADDR);
   endfunction

endpackage

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
   import uart_tx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] data,
   input  logic              addr,
   input  logic [1:0]        fmt,
   input  logic              msb_first,
   output logic [DATA_W+1:0] payload,
   output logic              long_frame
);

   logic [DATA_W-1:0] ordered;
   logic              ninth;

   for (genvar i = 0; i < DATA_W; i++) begin : g_order
      assign ordered[i] = msb_first ? data[DATA_W-1-i] : data[i];
   end

   always_comb begin
      unique case (fmt)
         FMT_PARITY: ninth = ^data;
         FMT_ADDR:   ninth = addr;
         default:    ninth = 1'b1;
      endcase
   end

   assign long_frame = fmt_long(fmt);
   assign payload    = {1'b1, ninth, ordered};

endmodule

// File: rtl/uart_tx_brkctl.sv
module uart_tx_brkctl (
   input  logic clk,
   input  logic rst_n,
   input  logic brk,
   input  logic brk_start,
   output logic brk_req
);

   logic pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (brk_start) begin
         pend_q <= 1'b0;
      end else if (brk) begin
         pend_q <= 1'b1;
      end
   end

   assign brk_req = brk | pend_q;

   // R9
   brk_remembered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(brk) && !$past(brk_start)) |-> brk_req);

endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk
   import uart_tx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [1:0]        fmt,
   input  logic              msb_first,
   input  logic              brk,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_addr,
   output logic              txd
);

   localparam int CNT_W = $clog2(DATA_W + 3);
   localparam int SH_W  = DATA_W + 2;
   localparam logic [CNT_W-1:0] REST_SHORT = CNT_W'(DATA_W + 1);
   localparam logic [CNT_W-1:0] REST_LONG  = CNT_W'(DATA_W + 2);

   if (DATA_W < 5 || DATA_W > 16) begin : g_bad_width
      $error("uart_tx_brk: DATA_W must lie in 5..16");
   end

   tx_st_e           st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [SH_W-1:0]  sh_q;
   logic             txd_q;

   logic [SH_W-1:0]  payload;
   logic             long_frame;
   logic             brk_req;
   logic             boundary;
   logic             start_brk;
   logic             start_dat;
   logic [CNT_W-1:0] rest_len;

   uart_tx_framer #(.DATA_W(DATA_W)) u_framer (
      .data       (s_data),
      .addr       (s_addr),
      .fmt        (fmt),
      .msb_first  (msb_first),
      .payload    (payload),
      .long_frame (long_frame)
   );

   uart_tx_brkctl u_brkctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .brk       (brk),
      .brk_start (start_brk),
      .brk_req   (brk_req)
   );

   always_comb begin
      boundary  = tick && ((st_q == ST_IDLE) || (cnt_q == '0));
      s_ready   = boundary && (st_q != ST_BRK) && !brk_req;
      start_brk = boundary && brk_req;
      start_dat = s_valid && s_ready;
      rest_len  = long_frame ? REST_LONG : REST_SHORT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         sh_q  <= '0;
         txd_q <= 1'b1;
      end else if (tick) begin
         if (start_brk) begin
            st_q  <= ST_BRK;
            cnt_q <= rest_len;
            sh_q  <= '0;
            txd_q <= 1'b0;
         end else if (start_dat) begin
            st_q  <= ST_DATA;
            cnt_q <= rest_len;
            sh_q  <= payload;
            txd_q <= 1'b0;
         end else if (boundary) begin
            st_q  <= ST_IDLE;
            txd_q <= 1'b1;
         end else begin
            txd_q <= sh_q[0];
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign txd = txd_q;

   // R12
   txd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(txd));

   // R3
   start_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready) |=> !txd);

   // R8
   brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_BRK) |-> !txd_q);

   // R10
   brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_BRK) && brk) |=> !txd_q);

   // R11
   mark_after_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st_q == ST_BRK) |-> txd_q);

endmodule

// File: tb/tb_uart_tx_brk.sv
module tb_uart_tx_brk;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [1:0] tcnt = 2'd0;
   logic [1:0] fmt = 2'd0;
   logic       msb_first = 1'b0;
   logic       brk = 1'b0;
   logic       s_valid = 1'b0;
   logic       s_ready;
   logic [7:0] s_data = 8'h00;
   logic       s_addr = 1'b0;
   logic       txd;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic       line[$];
   int         pos = 0;
   logic [7:0] q_d[$];
   logic       q_a[$];
   logic [1:0] q_f[$];
   logic       q_m[$];
   logic       prev_tick = 1'b0;

   uart_tx_brk dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .fmt(fmt), .msb_first(msb_first),
      .brk(brk), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
      .s_addr(s_addr), .txd(txd)
   );

   always #4 clk = ~clk;

   always @(posedge clk) begin
      tcnt <= tcnt + 2'd1;
      tick <= (tcnt == 2'd3);
   end

   initial begin
      forever begin
         @(negedge clk);
         if (prev_tick) line.push_back(txd);
         prev_tick = tick;
      end
   end

   function automatic logic [15:0] exp_bits(logic [7:0] d, logic a, logic [1:0] f, logic m);
      logic [15:0] v = '0;
      for (int i = 0; i < 8; i++) v[1+i] = m ? d[7-i] : d[i];
      if (f == 2'd1) begin v[9] = ^d; v[10] = 1'b1; end
      else if (f == 2'd2) begin v[9] = a; v[10] = 1'b1; end
      else v[9] = 1'b1;
      return v;
   endfunction

   function automatic int exp_len(logic [1:0] f);
      return (f == 2'd1 || f == 2'd2) ? 11 : 10;
   endfunction

   task automatic chk(bit ok, string req, int act, int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   task automatic clear_line();
      line.delete();
      pos = 0;
   endtask

   task automatic skip_ones(output int n);
      n = 0;
      while (pos < line.size() && line[pos] == 1'b1) begin n++; pos++; end
   endtask

   task automatic zero_run(output int n);
      n = 0;
      while (pos < line.size() && line[pos] == 1'b0) begin n++; pos++; end
   endtask

   task automatic check_frame(int k);
      int          len;
      logic [15:0] ev;
      logic [15:0] got;
      string       tag;
      len = exp_len(q_f[k]);
      ev  = exp_bits(q_d[k], q_a[k], q_f[k], q_m[k]);
      tag = (q_f[k] == 2'd1) ? "R3 R4 R5" : (q_f[k] == 2'd2) ? "R3 R4 R6" : "R3 R4";
      got = '0;
      if (pos + len > line.size()) begin
         chk(0, tag, line.size() - pos, len);
      end else begin
         for (int i = 0; i < len; i++) got[i] = line[pos+i];
         pos += len;
         chk(got == (ev & ((16'd1 << len) - 16'd1)), tag, got, ev);
      end
   endtask

   task automatic send(logic [7:0] d, logic a, logic [1:0] f, logic m);
      @(negedge clk);
      s_data = d; s_addr = a; fmt = f; msb_first = m; s_valid = 1'b1;
      while (!s_ready) @(negedge clk);
      q_d.push_back(d); q_a.push_back(a); q_f.push_back(f); q_m.push_back(m);
      @(negedge clk);
      s_valid = 1'b0;
   endtask

   task automatic decode_all(bit gaps_zero);
      int gap;
      for (int k = 0; k < q_d.size(); k++) begin
         skip_ones(gap);
         // R7: back-to-back words leave no idle bit
         if (gaps_zero && k > 0) chk(gap == 0, "R7", gap, 0);
         check_frame(k);
      end
      q_d.delete(); q_a.delete(); q_f.delete(); q_m.delete();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      finish_up();
   end

   initial begin
      int          n;
      int          zr;
      int          rdy_cnt;
      logic [31:0] seed_use;
      seed_use = $urandom(32'd20240);

      // R1: line high during reset
      repeat (10) @(negedge clk);
      chk(txd == 1'b1, "R1", txd, 1);
      rst_n = 1'b1;
      clear_line();
      repeat (40) @(negedge clk);
      skip_ones(n);
      // R1: no bits other than idle before any request
      chk(pos == line.size() && n > 5, "R1", n, line.size());

      // Directed back-to-back frames: orders, parity, address, reserved format
      clear_line();
      send(8'h01, 1'b0, 2'd0, 1'b0);
      send(8'h01, 1'b0, 2'd0, 1'b1);
      send(8'hA5, 1'b0, 2'd1, 1'b0);
      send(8'h07, 1'b0, 2'd1, 1'b1);
      send(8'h3C, 1'b1, 2'd2, 1'b0);
      send(8'h3C, 1'b0, 2'd2, 1'b1);
      send(8'h12, 1'b1, 2'd3, 1'b1);
      repeat (80) @(negedge clk);
      decode_all(1'b1);

      // Random words, formats, orders and gaps
      clear_line();
      for (int w = 0; w < 60; w++) begin
         send(8'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));
         // change controls after acceptance to show they were captured (R4)
         fmt = 2'($urandom); msb_first = 1'($urandom);
         repeat (4 * ($urandom % 3)) @(negedge clk);
      end
      repeat (80) @(negedge clk);
      decode_all(1'b0);

      // R9 R11: break pulse during a frame, a word waiting behind it
      clear_line();
      send(8'hC3, 1'b0, 2'd1, 1'b0);
      @(negedge clk); brk = 1'b1;
      @(negedge clk); brk = 1'b0;
      send(8'h5A, 1'b1, 2'd2, 1'b1);
      repeat (120) @(negedge clk);
      skip_ones(n);
      check_frame(0);
      zero_run(zr);
      // R8 R9: exactly one 11-bit zero frame right after the stop bit
      chk(zr == 11, "R8 R9", zr, 11);
      skip_ones(n);
      // R11: at least one mark bit before the next start bit
      chk(n >= 1, "R11", n, 1);
      check_frame(1);
      q_d.delete(); q_a.delete(); q_f.delete(); q_m.delete();

      // R10: break held over several frames in the 10-bit format
      clear_line();
      fmt = 2'd0;
      rdy_cnt = 0;
      @(negedge clk); brk = 1'b1;
      for (int c = 0; c < 180; c++) begin
         @(negedge clk);
         if (s_ready) rdy_cnt++;
      end
      brk = 1'b0;
      repeat (120) @(negedge clk);
      // R2: nothing accepted while a break is requested
      chk(rdy_cnt == 0, "R2", rdy_cnt, 0);
      skip_ones(n);
      zero_run(zr);
      chk((zr % 10 == 0) && zr >= 40, "R10", zr, 40);
      chk(pos < line.size() && line[pos] == 1'b1, "R11", pos, line.size());

      finish_up();
   end

endmodule